// File: doc/BRIEF.md
# Byte-Wide Parallel Port Transfer Engine

The engine moves 32-bit words between an on-chip word memory and an external memory that is only eight bits wide. Each word crosses a multiplexed address/data port as one address phase followed by four byte phases. Every phase lasts a programmable number of clocks. Software programs two pointer sets, one for the internal side and one for the external side, each with an index, a signed modify step and a count. It then writes a control word that picks the direction and the phase length and sets the two enable bits. It polls two busy outputs until both are low.

External addresses are physical byte addresses. Moving one word along the external side advances the byte pointer by four times the modify value, so a modify of -1 lays words out in descending order. The internal modify is a word stride, which lets the engine gather or scatter interleaved data.

The controller has four states. IDLE leaves on START, a control write with both enables set and both counts nonzero, and goes to ADDR. ADDR moves to DATA at the end of the address phase. DATA goes back to ADDR on NEXT_WORD, when the fourth byte finishes and words remain. DATA goes to DONE on LAST_WORD. DONE returns to IDLE after one clock. From ADDR or DATA, ABORT (a control write with either enable clear) returns to IDLE at once.

Top module: `pp_dma_engine`

## Requirements
- R1: After reset the engine is idle: `dma_busy`, `bus_busy`, `ext_ale`, `ext_wr`, `ext_rd`, `mem_re`, `mem_we` and `ext_ad_oe` are all low.
- R2: Register selects on `cfg_addr` are 0 control, 1 internal index, 2 internal modify, 3 internal count, 4 external byte index, 5 external modify, 6 external byte count. Control bit 0 is port enable, bit 1 is transfer enable, bit 2 selects transmit (1) or receive (0), and bits 7:4 give the phase length. A transfer starts only on a control write with bits 0 and 1 both set while idle with both counts nonzero. Any other write leaves `dma_busy` low.
- R3: Each word is one address phase with `ext_ale` high and the external byte address on `ext_ad_o`, followed by four data phases. Each phase lasts D clocks, where D is the phase-length field and a field of 0 counts as 1. A run of N words keeps `bus_busy` high for exactly 5·D·N clocks and `ext_ale` high for D·N of them.
- R4: In transmit, the word at the internal index is read when the address phase ends. Its bytes appear on `ext_ad_o[7:0]` least significant first, each marked by a one-clock `ext_wr` pulse in the last clock of its data phase. The external memory latches the address on `ext_ale` and steps by one byte per strobe.
- R5: In receive, `ext_ad_i` is sampled at each one-clock `ext_rd` pulse, least significant byte first. The assembled word is written to the internal index with `mem_we` in the clock of the fourth `ext_rd`. `ext_ad_oe` is low throughout the data phases.
- R6: After each word the internal index advances by the signed internal modify, in words.
- R7: After each word the external byte index advances by four times the signed external modify. A negative modify produces descending addresses.
- R8: After each word the internal count drops by 1 and the external count drops by 4. The transfer ends after the word in which the internal count was 1 or the external count was 4 or less. No further word is touched.
- R9: `dma_busy` is high from the clock after START for 5·D·N+1 clocks, one clock longer than `bus_busy`. Both are low afterwards.
- R10: A control write with bit 0 or bit 1 clear stops a running transfer. In the next clock `dma_busy`, `bus_busy` and all strobes are low, and no more bytes move.
- R11: Writes to the index, modify and count registers while `dma_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| mem_addr | output | 10 | Internal word address (internal index) |
| mem_re | output | 1 | Internal read strobe (transmit) |
| mem_rdata | input | 32 | Internal read data, valid for the current `mem_addr` |
| mem_we | output | 1 | Internal write strobe (receive) |
| mem_wdata | output | 32 | Internal write data |
| ext_ad_o | output | 16 | Multiplexed port: byte address in the address phase, byte in bits 7:0 in transmit data phases |
| ext_ad_oe | output | 1 | Port output enable |
| ext_ad_i | input | 8 | Port input byte |
| ext_ale | output | 1 | Address latch enable, high for the whole address phase |
| ext_wr | output | 1 | Byte write strobe |
| ext_rd | output | 1 | Byte read strobe |
| bus_busy | output | 1 | High during address and data phases |
| dma_busy | output | 1 | High while a transfer is in progress, including the completion clock |

## Verification
The bench goes after phase lengths of 0 and 1, where a design that took the field literally would hang or stretch every phase, and after busy-window counts that would be off by one if the completion clock or the address phase were miscounted. It runs negative external modifies and odd internal strides. A sign or scaling slip there would scatter bytes to the wrong physical addresses, and a reversed byte order would swap lanes inside each word. It also checks a run cut short by a small external count, a write-back of the word one past the end, an abort that lets another byte slip out, and pointer writes during a run that would redirect or shorten it.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } pp_state_e;

    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_INT_IDX = 3'd1;
    localparam logic [2:0] REG_INT_MOD = 3'd2;
    localparam logic [2:0] REG_INT_CNT = 3'd3;
    localparam logic [2:0] REG_EXT_IDX = 3'd4;
    localparam logic [2:0] REG_EXT_MOD = 3'd5;
    localparam logic [2:0] REG_EXT_CNT = 3'd6;

    localparam int CTRL_PORT_EN = 0;
    localparam int CTRL_XFER_EN = 1;
    localparam int CTRL_TX      = 2;
    localparam int CTRL_DUR_LO  = 4;

endpackage

// File: rtl/pp_dur_timer.sv
module pp_dur_timer #(
    parameter int DUR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DUR_W-1:0] dur,
    output logic             tick
);
    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] last;

    // A zero setting is treated as one clock per phase.
    always_comb begin
        last = (dur == '0) ? '0 : dur - DUR_W'(1);
        tick = !hold && (cnt_q == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hold || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DUR_W'(1);
    end
endmodule

// File: rtl/pp_ptr_unit.sv
module pp_ptr_unit #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 16,
    parameter int CNT_W  = 16,
    parameter int SHIFT  = 0,
    parameter int DEC    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_idx,
    input  logic              wr_mod,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [IDX_W-1:0]  idx,
    output logic [CNT_W-1:0]  cnt
);
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] mod_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] stride;

    // Two's-complement modify wraps with the index, so the sign needs no extension.
    assign stride = mod_q << SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            mod_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_idx)
                idx_q <= wdata[IDX_W-1:0];
            else if (step)
                idx_q <= idx_q + stride;
            if (wr_mod)
                mod_q <= wdata[IDX_W-1:0];
            if (wr_cnt)
                cnt_q <= wdata[CNT_W-1:0];
            else if (step)
                cnt_q <= cnt_q - CNT_W'(DEC);
        end
    end

    assign idx = idx_q;
    assign cnt = cnt_q;
endmodule

// File: rtl/pp_word_shifter.sv
module pp_word_shifter #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] word_next
);
    logic [WORD_W-1:0] sh_q;

    // Bytes leave from the low end and arrive at the high end: least significant first.
    assign word_next = {byte_in, sh_q[WORD_W-1:BYTE_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= load_val;
        else if (shift)
            sh_q <= word_next;
    end

    assign word = sh_q;
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int INT_AW = 10,
    parameter int EXT_AW = 16,
    parameter int CNT_W  = 16,
    parameter int DUR_W  = 4,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [INT_AW-1:0] mem_addr,
    output logic              mem_re,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [EXT_AW-1:0] ext_ad_o,
    output logic              ext_ad_oe,
    input  logic [BYTE_W-1:0] ext_ad_i,
    output logic              ext_ale,
    output logic              ext_wr,
    output logic              ext_rd,
    output logic              bus_busy,
    output logic              dma_busy
);
    localparam int BYTES    = WORD_W / BYTE_W;
    localparam int BSEL_W   = $clog2(BYTES);
    localparam int BYTE_SH  = $clog2(BYTES);
    localparam logic [BSEL_W-1:0] LAST_BYTE = BSEL_W'(BYTES - 1);

    pp_state_e state_q, state_d;

    logic             tx_q;
    logic [DUR_W-1:0] dur_q;
    logic [BSEL_W-1:0] bsel_q;

    logic ctrl_wr, abort_req, start_req, ptr_wr_ok;
    logic tick, last_byte, finish, step;
    logic [INT_AW-1:0] int_idx;
    logic [CNT_W-1:0]  int_cnt;
    logic [EXT_AW-1:0] ext_idx;
    logic [CNT_W-1:0]  ext_cnt;
    logic [WORD_W-1:0] sh_word, sh_next;

    assign ctrl_wr   = cfg_we && (cfg_addr == REG_CTRL);
    assign abort_req = ctrl_wr && !(cfg_wdata[CTRL_PORT_EN] && cfg_wdata[CTRL_XFER_EN]);
    assign start_req = ctrl_wr && cfg_wdata[CTRL_PORT_EN] && cfg_wdata[CTRL_XFER_EN]
                       && (int_cnt != '0) && (ext_cnt != '0);
    assign ptr_wr_ok = cfg_we && (state_q == ST_IDLE);

    assign last_byte = (state_q == ST_DATA) && tick && (bsel_q == LAST_BYTE);
    assign step      = last_byte;
    assign finish    = (int_cnt == CNT_W'(1)) || (ext_cnt <= CNT_W'(BYTES));

    pp_dur_timer #(.DUR_W(DUR_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  ((state_q == ST_IDLE) || (state_q == ST_DONE)),
        .dur   (dur_q),
        .tick  (tick)
    );

    pp_ptr_unit #(
        .DATA_W(REG_W), .IDX_W(INT_AW), .CNT_W(CNT_W), .SHIFT(0), .DEC(1)
    ) i_int_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_idx (ptr_wr_ok && (cfg_addr == REG_INT_IDX)),
        .wr_mod (ptr_wr_ok && (cfg_addr == REG_INT_MOD)),
        .wr_cnt (ptr_wr_ok && (cfg_addr == REG_INT_CNT)),
        .wdata  (cfg_wdata),
        .step   (step),
        .idx    (int_idx),
        .cnt    (int_cnt)
    );

    pp_ptr_unit #(
        .DATA_W(REG_W), .IDX_W(EXT_AW), .CNT_W(CNT_W), .SHIFT(BYTE_SH), .DEC(BYTES)
    ) i_ext_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_idx (ptr_wr_ok && (cfg_addr == REG_EXT_IDX)),
        .wr_mod (ptr_wr_ok && (cfg_addr == REG_EXT_MOD)),
        .wr_cnt (ptr_wr_ok && (cfg_addr == REG_EXT_CNT)),
        .wdata  (cfg_wdata),
        .step   (step),
        .idx    (ext_idx),
        .cnt    (ext_cnt)
    );

    pp_word_shifter #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      ((state_q == ST_ADDR) && tick && tx_q),
        .load_val  (mem_rdata),
        .shift     ((state_q == ST_DATA) && tick),
        .byte_in   (tx_q ? '0 : ext_ad_i),
        .word      (sh_word),
        .word_next (sh_next)
    );

    // Control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= 1'b0;
            dur_q <= '0;
        end else if (ctrl_wr) begin
            tx_q  <= cfg_wdata[CTRL_TX];
            dur_q <= cfg_wdata[CTRL_DUR_LO +: DUR_W];
        end
    end

    // Byte position within the current word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bsel_q <= '0;
        else if (state_q != ST_DATA)
            bsel_q <= '0;
        else if (tick)
            bsel_q <= bsel_q + BSEL_W'(1);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_ADDR;
            ST_ADDR: begin
                if (abort_req)   state_d = ST_IDLE;
                else if (tick)   state_d = ST_DATA;
            end
            ST_DATA: begin
                if (abort_req)      state_d = ST_IDLE;
                else if (last_byte) state_d = finish ? ST_DONE : ST_ADDR;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        mem_addr  = int_idx;
        mem_wdata = sh_next;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        ext_ale   = 1'b0;
        ext_wr    = 1'b0;
        ext_rd    = 1'b0;
        ext_ad_oe = 1'b0;
        ext_ad_o  = '0;
        bus_busy  = 1'b0;
        dma_busy  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                ext_ale   = 1'b1;
                ext_ad_oe = 1'b1;
                ext_ad_o  = ext_idx;
                mem_re    = tx_q && tick;
                bus_busy  = 1'b1;
                dma_busy  = 1'b1;
            end
            ST_DATA: begin
                ext_ad_oe = tx_q;
                ext_ad_o  = tx_q ? EXT_AW'(sh_word[BYTE_W-1:0]) : '0;
                ext_wr    = tx_q && tick;
                ext_rd    = !tx_q && tick;
                mem_we    = !tx_q && last_byte;
                bus_busy  = 1'b1;
                dma_busy  = 1'b1;
            end
            ST_DONE: dma_busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pp_dma_checker.sv
module pp_dma_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       cfg_addr,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             mem_re,
    input logic             mem_we,
    input logic             ext_ale,
    input logic             ext_wr,
    input logic             ext_rd,
    input logic             ext_ad_oe,
    input logic             bus_busy,
    input logic             dma_busy
);
    logic ctrl_wr, ctrl_off;
    assign ctrl_wr  = cfg_we && (cfg_addr == 3'd0);
    assign ctrl_off = ctrl_wr && !(cfg_wdata[0] && cfg_wdata[1]);

    p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_busy && !ctrl_wr) |=> !dma_busy);

    p_ale_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |-> (!ext_wr && !ext_rd && ext_ad_oe));

    p_addr_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ext_ale) && dma_busy) |-> bus_busy);

    p_wr_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |-> (ext_ad_oe && !ext_rd));

    p_fetch_in_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ext_ale);

    p_rd_floats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd |-> !ext_ad_oe);

    p_store_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ext_rd);

    p_bus_within_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> dma_busy);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off |=> (!dma_busy && !ext_ale && !ext_wr && !ext_rd));
endmodule

bind pp_dma_engine pp_dma_checker #(.REG_W(REG_W)) i_chk (.*);

// File: tb/test_pp_dma_engine.sv
`timescale 1ns/1ps
module test_pp_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [9:0]  mem_addr;
    logic        mem_re, mem_we;
    logic [31:0] mem_rdata, mem_wdata;
    logic [15:0] ext_ad_o;
    logic        ext_ad_oe, ext_ale, ext_wr, ext_rd, bus_busy, dma_busy;
    logic [7:0]  ext_ad_i;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pp_dma_engine i_pp_dma_engine (.*);

    // Memory models
    logic [31:0] int_mem [0:1023];
    logic [7:0]  ext_mem [0:65535];
    logic [15:0] lat_q = '0;
    logic [1:0]  k_q = '0;

    assign mem_rdata = int_mem[mem_addr];
    assign ext_ad_i  = ext_mem[lat_q + 16'(k_q)];

    always @(posedge clk) begin
        if (mem_we) int_mem[mem_addr] <= mem_wdata;
        if (ext_ale) begin
            lat_q <= ext_ad_o;
            k_q   <= '0;
        end else if (ext_wr) begin
            ext_mem[lat_q + 16'(k_q)] <= ext_ad_o[7:0];
            k_q <= k_q + 2'd1;
        end else if (ext_rd) begin
            k_q <= k_q + 2'd1;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ext_addr(input int e0, input int emod, input int k, input int b);
        return 16'(e0 + emod * 4 * k + b);
    endfunction

    function automatic logic [9:0] int_addr(input int i0, input int imod, input int k);
        return 10'(i0 + imod * k);
    endfunction

    function automatic int dur_eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Program, start, measure and check one transfer of "words" words.
    task automatic run_xfer(input bit tx, input int d, input int i0, input int imod,
                            input int icnt, input int e0, input int emod, input int ecnt,
                            input int words, input bit poke);
        int busy = 0, bus = 0, ale = 0, strb = 0, guard = 0;
        logic [31:0] snap_int;
        logic [7:0]  snap_ext;
        reg_wr(3'd1, 16'(i0));  reg_wr(3'd2, 16'(imod)); reg_wr(3'd3, 16'(icnt));
        reg_wr(3'd4, 16'(e0));  reg_wr(3'd5, 16'(emod)); reg_wr(3'd6, 16'(ecnt));
        snap_int = int_mem[int_addr(i0, imod, words)];
        snap_ext = ext_mem[ext_addr(e0, emod, words, 0)];
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0;
        cfg_wdata = 16'((d << 4) | (int'(tx) << 2) | 3);
        @(negedge clk);
        cfg_we = 1'b0;
        while (dma_busy && guard < 20000) begin
            busy++;
            if (bus_busy) bus++;
            if (ext_ale) ale++;
            if (ext_wr || ext_rd) strb++;
            if (poke && busy == 2) begin cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 16'd1; end
            if (poke && busy == 3) begin cfg_addr = 3'd1; cfg_wdata = 16'h0; end
            if (poke && busy == 4) cfg_we = 1'b0;
            guard++;
            @(negedge clk);
        end
        check(busy == 5 * dur_eff(d) * words + 1, poke ? "R11 run length after pokes" : "R9 dma_busy window",
              busy, 5 * dur_eff(d) * words + 1);
        check(bus == 5 * dur_eff(d) * words, "R3 bus_busy window", bus, 5 * dur_eff(d) * words);
        check(ale == dur_eff(d) * words, "R3 ext_ale clocks", ale, dur_eff(d) * words);
        check(strb == 4 * words, tx ? "R4 write strobes" : "R5 read strobes", strb, 4 * words);
        check(!dma_busy && !bus_busy, "R9 both busy low after run", dma_busy, 0);
        for (int k = 0; k < words; k++) begin
            logic [31:0] exp_w, act_w;
            for (int b = 0; b < 4; b++) begin
                if (tx) begin
                    exp_w[8*b +: 8] = int_mem[int_addr(i0, imod, k)][8*b +: 8];
                    act_w[8*b +: 8] = ext_mem[ext_addr(e0, emod, k, b)];
                end else begin
                    exp_w[8*b +: 8] = ext_mem[ext_addr(e0, emod, k, b)];
                end
            end
            if (!tx) act_w = int_mem[int_addr(i0, imod, k)];
            check(act_w == exp_w, tx ? "R4/R6/R7 transmit word" : "R5/R6/R7 receive word", act_w, exp_w);
        end
        if (words < icnt) begin
            if (tx) check(ext_mem[ext_addr(e0, emod, words, 0)] == snap_ext,
                          "R8 byte past end untouched", ext_mem[ext_addr(e0, emod, words, 0)], snap_ext);
            else    check(int_mem[int_addr(i0, imod, words)] == snap_int,
                          "R8 word past end untouched", int_mem[int_addr(i0, imod, words)], snap_int);
        end
    endtask

    int mods_i [5] = '{1, 2, 3, -1, -2};
    int mods_e [4] = '{1, -1, 2, -3};

    initial begin
        void'($urandom(32'd20061025));
        for (int i = 0; i < 1024; i++) int_mem[i] = $urandom;
        for (int i = 0; i < 65536; i++) ext_mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!dma_busy && !bus_busy && !ext_ale && !ext_wr && !ext_rd && !mem_re && !mem_we && !ext_ad_oe,
              "R1 idle outputs in reset", {dma_busy, bus_busy, ext_ale, ext_wr, ext_rd, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dma_busy && !bus_busy, "R1 idle after reset release", dma_busy, 0);

        // Directed: transmit, stride 2, ascending
        run_xfer(1'b1, 3, 10, 2, 4, 16'h0100, 1, 16, 4, 1'b0);
        // Directed: receive, stride 3, descending external
        run_xfer(1'b0, 2, 40, 3, 3, 16'h2000, -1, 12, 3, 1'b0);
        // Phase length 0 behaves as 1
        run_xfer(1'b1, 0, 100, -1, 5, 16'h3000, -1, 20, 5, 1'b0);
        run_xfer(1'b0, 1, 200, 1, 2, 16'hFFFC, 1, 8, 2, 1'b0);
        // External count ends the run early (R8)
        run_xfer(1'b0, 2, 300, 1, 6, 16'h4000, 2, 8, 2, 1'b0);
        run_xfer(1'b1, 1, 320, 2, 6, 16'h4800, 1, 4, 1, 1'b0);
        // Pointer writes during the run are ignored (R11)
        run_xfer(1'b1, 2, 400, 1, 4, 16'h5000, 1, 16, 4, 1'b1);

        // R2: no start with one enable, nor with a zero count
        reg_wr(3'd3, 16'd4); reg_wr(3'd6, 16'd16);
        reg_wr(3'd0, 16'h0016);
        repeat (2) @(negedge clk);
        check(!dma_busy && !ext_ale, "R2 transfer enable alone starts nothing", dma_busy, 0);
        reg_wr(3'd0, 16'h0015);
        repeat (2) @(negedge clk);
        check(!dma_busy && !ext_ale, "R2 port enable alone starts nothing", dma_busy, 0);
        reg_wr(3'd3, 16'd0);
        reg_wr(3'd0, 16'h0017);
        repeat (2) @(negedge clk);
        check(!dma_busy && !ext_ale, "R2 zero count starts nothing", dma_busy, 0);

        // R10: abort mid-run
        begin
            int strb = 0;
            reg_wr(3'd1, 16'd500); reg_wr(3'd2, 16'd1); reg_wr(3'd3, 16'd8);
            reg_wr(3'd4, 16'h6000); reg_wr(3'd5, 16'd1); reg_wr(3'd6, 16'd32);
            reg_wr(3'd0, 16'h0027);
            repeat (16) @(negedge clk);
            check(dma_busy, "R10 run in progress before abort", dma_busy, 1);
            cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'h0000;
            @(negedge clk);
            cfg_we = 1'b0;
            check(!dma_busy && !bus_busy && !ext_ale && !ext_wr && !ext_ad_oe,
                  "R10 idle one clock after abort", {dma_busy, bus_busy, ext_ale, ext_wr}, 0);
            for (int i = 0; i < 30; i++) begin
                if (ext_wr || ext_rd || ext_ale) strb++;
                @(negedge clk);
            end
            check(strb == 0, "R10 no activity after abort", strb, 0);
        end

        // Constrained random transfers
        for (int t = 0; t < 10; t++) begin
            bit tx = 1'($urandom);
            int d  = int'($urandom_range(0, 4));
            int n  = int'($urandom_range(1, 6));
            int im = mods_i[$urandom_range(0, 4)];
            int em = mods_e[$urandom_range(0, 3)];
            run_xfer(tx, d, int'($urandom_range(0, 1023)), im, n,
                     int'($urandom_range(0, 65535)), em, 4 * n, n, 1'b0);
        end

        summary();
        $finish;
    end
endmodule